// File: doc/BRIEF.md
# External Interrupt Edge Timestamper

This block takes three asynchronous external interrupt pins and turns each into a clean single-cycle interrupt pulse. Every channel has its own enable and its own edge-polarity choice. Each pin first passes through a multi-flop synchronizer. An edge detector then compares the synchronized level with its value one cycle earlier.

Each channel also has a free-running up counter that returns to zero on every edge that raises an interrupt. Software reads the counter to learn how many clocks have passed since the last accepted event. A write port updates the enable and polarity fields of one channel at a time. A read port returns the counter of the selected channel.

Top module: `ext_irq_stamp`

## Requirements
- R1: The block has three independent channels (NUM_CH = 3). An edge on one pin produces a pulse only on the irq_o bit with the same index.
- R2: When a channel's polarity field is 1 (rising), a 0-to-1 transition on its pin gives a pulse and a 1-to-0 transition gives none.
- R3: When a channel's polarity field is 0 (falling), a 1-to-0 transition on its pin gives a pulse and a 0-to-1 transition gives none.
- R4: A channel whose enable field is 0 gives no pulse on any pin transition, and its counter is not cleared.
- R5: Each counter is CNT_W = 16 bits wide and grows by exactly one on every clock that does not clear it.
- R6: An interrupt pulse lasts one clock cycle. The counter of that channel reads 0 in the same cycle the pulse is high.
- R7: A pulse appears after the third rising clock edge that follows the pin change: two synchronizer stages plus one detection register.
- R8: A counter wraps from 0xFFFF to 0x0000 and does not saturate.
- R9: Changing a channel's polarity field while its pin is steady gives neither a pulse nor a counter clear.
- R10: After reset, every channel is disabled, every polarity field is 0 (falling), every counter is 0 and every irq_o bit is 0. Writing only the enable field leaves the polarity at falling.
- R11: rd_cnt_o shows the counter of the channel chosen by rd_sel_i in the same cycle. A selection of NUM_CH or above reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | NUM_CH | Raw asynchronous interrupt pins |
| cfg_sel_i | input | SEL_W | Channel addressed by a configuration write |
| cfg_en_we_i | input | 1 | Write strobe for the enable field |
| cfg_en_i | input | 1 | New enable value |
| cfg_pol_we_i | input | 1 | Write strobe for the polarity field |
| cfg_rise_i | input | 1 | New polarity: 1 selects rising, 0 selects falling |
| rd_sel_i | input | SEL_W | Channel whose counter is shown on rd_cnt_o |
| rd_cnt_o | output | CNT_W | Counter of the selected channel |
| irq_o | output | NUM_CH | Single-cycle interrupt pulse per channel |

## Verification
The assertions check several properties on every cycle. A pulse never lasts two cycles. A disabled channel never pulses. Every pulse matches the chosen polarity of the synchronized level. The counter either reads zero after a clear or has stepped by exactly one, which also covers the wrap. Only the bench scenarios can show the end-to-end behaviour. Those checks are the three-edge latency from the raw pin, the separation between channels, the absence of a pulse when polarity is rewritten on a steady pin, the default polarity after reset, and the out-of-range read value.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

   typedef struct packed {
      logic en;
      logic rise;
   } chan_cfg_t;

   localparam chan_cfg_t CFG_RESET = '{en: 1'b0, rise: 1'b0};

endpackage

// File: rtl/eit_sync.sv
module eit_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("eit_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/eit_edge.sv
module eit_edge
   import ext_irq_pkg::*;
(
   input  logic      clk_i,
   input  logic      rst_ni,
   input  logic      lvl_i,
   input  chan_cfg_t cfg_i,
   output logic      hit_o,
   output logic      irq_o
);

   logic prev_q;
   logic irq_q;
   logic rise_ev;
   logic fall_ev;

   assign rise_ev = lvl_i & ~prev_q;
   assign fall_ev = ~lvl_i & prev_q;
   assign hit_o   = cfg_i.en & (cfg_i.rise ? rise_ev : fall_ev);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         prev_q <= 1'b0;
         irq_q  <= 1'b0;
      end else begin
         prev_q <= lvl_i;
         irq_q  <= hit_o;
      end
   end

   assign irq_o = irq_q;

   // R6
   irq_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_q |=> !irq_q);

   // R4
   irq_disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cfg_i.en |=> !irq_q);

   // R2
   irq_polarity_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_q |-> ($past(lvl_i) == $past(cfg_i.rise)));

endmodule

// File: rtl/eit_stamp.sv
module eit_stamp #(
   parameter int W = 16
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         clr_i,
   output logic [W-1:0] cnt_o
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    cnt_q <= '0;
      else if (clr_i) cnt_q <= '0;
      else            cnt_q <= cnt_q + 1'b1;
   end

   assign cnt_o = cnt_q;

   // R6
   cnt_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> (cnt_q == '0));

   // R5 and R8
   cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !clr_i |=> (cnt_q == W'($past(cnt_q) + 1'b1)));

endmodule

// File: rtl/ext_irq_stamp.sv
module ext_irq_stamp
   import ext_irq_pkg::*;
#(
   parameter int NUM_CH      = 3,
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2,
   localparam int SEL_W      = (NUM_CH > 1) ? $clog2(NUM_CH + 1) : 1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [NUM_CH-1:0] pin_i,
   input  logic [SEL_W-1:0]  cfg_sel_i,
   input  logic              cfg_en_we_i,
   input  logic              cfg_en_i,
   input  logic              cfg_pol_we_i,
   input  logic              cfg_rise_i,
   input  logic [SEL_W-1:0]  rd_sel_i,
   output logic [CNT_W-1:0]  rd_cnt_o,
   output logic [NUM_CH-1:0] irq_o
);

   generate
      if (NUM_CH < 1) begin : g_bad_ch
         $error("ext_irq_stamp: NUM_CH must be at least 1");
      end
      if (CNT_W < 2) begin : g_bad_w
         $error("ext_irq_stamp: CNT_W must be at least 2");
      end
   endgenerate

   chan_cfg_t        cfg_q [NUM_CH];
   logic [CNT_W-1:0] cnt_w [NUM_CH];
   logic [NUM_CH-1:0] lvl_w;
   logic [NUM_CH-1:0] hit_w;

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      logic sel_me;
      assign sel_me = (cfg_sel_i == SEL_W'(g));

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            cfg_q[g] <= CFG_RESET;
         end else begin
            if (sel_me && cfg_en_we_i)  cfg_q[g].en   <= cfg_en_i;
            if (sel_me && cfg_pol_we_i) cfg_q[g].rise <= cfg_rise_i;
         end
      end

      eit_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk_i (clk_i),
         .rst_ni(rst_ni),
         .d_i   (pin_i[g]),
         .q_o   (lvl_w[g])
      );

      eit_edge u_edge (
         .clk_i (clk_i),
         .rst_ni(rst_ni),
         .lvl_i (lvl_w[g]),
         .cfg_i (cfg_q[g]),
         .hit_o (hit_w[g]),
         .irq_o (irq_o[g])
      );

      eit_stamp #(.W(CNT_W)) u_stamp (
         .clk_i (clk_i),
         .rst_ni(rst_ni),
         .clr_i (hit_w[g]),
         .cnt_o (cnt_w[g])
      );

      // R6
      cnt_zero_on_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         irq_o[g] |-> (cnt_w[g] == '0));
   end

   always_comb begin
      rd_cnt_o = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (rd_sel_i == SEL_W'(i)) rd_cnt_o = cnt_w[i];
      end
   end

endmodule

// File: tb/tb_ext_irq_stamp.sv
module tb_ext_irq_stamp;

   localparam int NCH = 3;
   localparam int SW  = 2;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [NCH-1:0] pin = '0;
   logic [SW-1:0]  cfg_sel = '0;
   logic           en_we = 1'b0, en_v = 1'b0, pol_we = 1'b0, rise_v = 1'b0;
   logic [SW-1:0]  rd_sel = '0;
   logic [15:0]    rd_cnt;
   logic [NCH-1:0] irq;

   ext_irq_stamp dut (
      .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .cfg_sel_i(cfg_sel),
      .cfg_en_we_i(en_we), .cfg_en_i(en_v), .cfg_pol_we_i(pol_we),
      .cfg_rise_i(rise_v), .rd_sel_i(rd_sel), .rd_cnt_o(rd_cnt), .irq_o(irq)
   );

   always #5 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   typedef struct {
      int    ch;
      int    at;
      string req;
   } exp_t;

   exp_t q[$];
   int   base [NCH];
   bit   en_m [NCH];
   bit   rise_m [NCH];
   bit   pin_m [NCH];
   int   n_chk = 0;
   int   n_fail = 0;

   task automatic chk(bit ok, string req, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   // monitor: pops the scoreboard as pulses appear
   always @(negedge clk) begin
      exp_t it;
      if (rst_n) begin
         if (q.size() > 0 && q[0].at < cyc) begin
            it = q.pop_front();
            chk(1'b0, {it.req, " R7 missing pulse"}, 0, it.ch);
         end
         for (int c = 0; c < NCH; c++) begin
            if (irq[c]) begin
               if (q.size() == 0) begin
                  chk(1'b0, "R4/R9/R6 unexpected pulse", c, -1);
               end else begin
                  it = q.pop_front();
                  chk(it.ch == c, {it.req, " R1 channel"}, c, it.ch);
                  chk(it.at == cyc, {it.req, " R7 timing"}, cyc, it.at);
               end
            end
         end
      end
   end

   // driver: call right after a negedge
   task automatic drive_pin(int ch, bit v, string req);
      bit old;
      old = pin_m[ch];
      pin[ch] = v;
      pin_m[ch] = v;
      if (en_m[ch] && (rise_m[ch] ? (!old && v) : (old && !v))) begin
         q.push_back('{ch: ch, at: cyc + 3, req: req});
         base[ch] = cyc + 3;
      end
   endtask

   task automatic set_pin(int ch, bit v, string req);
      @(negedge clk);
      drive_pin(ch, v, req);
      repeat (6) @(negedge clk);
   endtask

   task automatic cfg(int ch, bit wen, bit e, bit wpol, bit r);
      @(negedge clk);
      cfg_sel = SW'(ch); en_we = wen; en_v = e; pol_we = wpol; rise_v = r;
      if (wen) en_m[ch] = e;
      if (wpol) rise_m[ch] = r;
      @(negedge clk);
      en_we = 1'b0; pol_we = 1'b0;
   endtask

   task automatic check_cnts(string req);
      @(negedge clk);
      for (int c = 0; c < NCH; c++) begin
         rd_sel = SW'(c);
         #1;
         chk(rd_cnt == 16'(cyc - base[c]), req, rd_cnt, 16'(cyc - base[c]));
      end
      rd_sel = SW'(3);
      #1;
      chk(rd_cnt == 16'h0, "R11 out-of-range read", rd_cnt, 0);
   endtask

   initial begin
      while (cyc < 200000) @(posedge clk);
      chk(1'b0, "watchdog", cyc, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      for (int c = 0; c < NCH; c++) begin
         en_m[c] = 0; rise_m[c] = 0; pin_m[c] = 0;
      end
      repeat (3) @(negedge clk);
      // R10 reset state
      chk(irq == '0, "R10 irq at reset", irq, 0);
      for (int c = 0; c < NCH; c++) begin
         rd_sel = SW'(c);
         #1;
         chk(rd_cnt == 16'h0, "R10 counter at reset", rd_cnt, 0);
      end
      @(negedge clk);
      rst_n = 1'b1;
      for (int c = 0; c < NCH; c++) base[c] = cyc;
      check_cnts("R5 counting after reset");

      // R4: disabled channel, both edges
      set_pin(0, 1'b1, "R4");
      set_pin(0, 1'b0, "R4");
      check_cnts("R4 no clear when disabled");

      // R10: enable only, polarity stays falling; R3
      cfg(0, 1'b1, 1'b1, 1'b0, 1'b0);
      set_pin(0, 1'b1, "R3 rising ignored");
      check_cnts("R10 default falling");
      @(negedge clk);
      drive_pin(0, 1'b0, "R3");
      repeat (3) @(negedge clk);
      rd_sel = SW'(0);
      #1;
      chk(rd_cnt == 16'h0, "R6 counter zero with pulse", rd_cnt, 0);
      chk(irq[0] == 1'b1, "R6 pulse present", irq[0], 1);
      repeat (4) @(negedge clk);
      check_cnts("R5 after falling clear");

      // R2 rising on channel 1
      cfg(1, 1'b1, 1'b1, 1'b1, 1'b1);
      set_pin(1, 1'b1, "R2");
      set_pin(1, 1'b0, "R2 falling ignored");
      check_cnts("R2 counters");

      // R9: polarity change on steady pin
      set_pin(1, 1'b1, "R2");
      cfg(1, 1'b0, 1'b0, 1'b1, 1'b0);
      repeat (5) @(negedge clk);
      check_cnts("R9 no clear on polarity change");
      cfg(1, 1'b0, 1'b0, 1'b1, 1'b1);
      cfg(1, 1'b0, 1'b0, 1'b1, 1'b0);
      repeat (5) @(negedge clk);
      check_cnts("R9 repeated polarity writes");
      set_pin(1, 1'b0, "R9 falling after change");
      check_cnts("R9 counters");

      // R1: simultaneous edges on two channels
      cfg(2, 1'b1, 1'b1, 1'b1, 1'b1);
      @(negedge clk);
      drive_pin(0, 1'b1, "R1");
      drive_pin(2, 1'b1, "R1");
      repeat (6) @(negedge clk);
      @(negedge clk);
      drive_pin(0, 1'b0, "R1");
      drive_pin(2, 1'b0, "R1");
      repeat (6) @(negedge clk);
      check_cnts("R1 independent counters");

      // R8 wrap on channel 1
      while (16'(cyc - base[1]) != 16'hFFFF) @(negedge clk);
      rd_sel = SW'(1);
      #1;
      chk(rd_cnt == 16'hFFFF, "R8 top value", rd_cnt, 16'hFFFF);
      @(negedge clk);
      #1;
      chk(rd_cnt == 16'h0000, "R8 wrap to zero", rd_cnt, 0);
      @(negedge clk);
      #1;
      chk(rd_cnt == 16'h0001, "R8 after wrap", rd_cnt, 1);
      check_cnts("R5 after long run");

      repeat (5) @(negedge clk);
      chk(q.size() == 0, "R7 pending expected pulses", q.size(), 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule